// File: doc/BRIEF.md
# Block Read Data Transmitter (4-bit card bus)

This block is the card-side sender for read data on a four-line data bus. Once the command path has answered a read request, it raises a start strobe. From then on the block pulls bytes from an upstream source over a valid/ready handshake and turns each block into a serial frame. A frame is an access gap, a start bit, the payload two nibbles per byte, a separate 16-bit CRC on each line, and an end bit. Each payload byte goes out high nibble first.

A mode flag sampled with the start strobe selects the transfer type. In single mode the block sends one block and then releases the bus. In multiple mode it sends blocks back to back, with an access gap before each one, until the command path reports the end bit of a stop command. The stop cuts the stream at a fixed point, even in the middle of a block. The block length and the access delay are programmed values, latched when a transfer starts.

Top module: `blk_read_tx`

## Requirements
- R1: After reset, and while no transfer is running, all output enables are low (`dat_oe_o` = 0000) and `byte_ready_o` is low.
- R2: If the start strobe is sampled at a clock edge, the NAC output cycles after that edge form the access gap. All but the last gap cycle are released (enables 0000). The last gap cycle drives 1111 with enables 1111. The start bit, 0000 with enables 1111, comes in cycle NAC+1.
- R3: After the start bit, each payload byte takes two cycles. Line k carries bit k of the high nibble (byte bits 7:4) first, then bit k of the low nibble (bits 3:0). Bytes go out in the order the source delivers them.
- R4: After the last payload nibble, each line sends 16 cycles of its own CRC, most significant bit first. The CRC uses polynomial x^16+x^12+x^5+1 (0x1021), starts from zero and covers only that line's payload bits. One end bit (1111, enabled) follows the CRC.
- R5: In single mode, outputs are released from the cycle after the end bit. A new start strobe is accepted from then on.
- R6: In multiple mode, each further block repeats the R2 gap pattern of NAC cycles right after the previous end bit. Its start bit comes NAC+1 cycles after that end bit.
- R7: If the stop strobe is sampled at an edge during a transfer, the next output cycle continues the frame normally. The cycle after that drives an end bit (1111, enabled). Two released cycles follow, after which the block is idle.
- R8: A stop strobe sampled while idle has no effect, and the outputs stay released. A start strobe, or a change of mode, length or delay inputs, during a running transfer does not alter the frame sequence.
- R9: If the first byte of a block has not arrived by the end of the access gap, the gap is extended. The line keeps driving 1111 until the byte is accepted, and the start bit follows in the next cycle.
- R10: `byte_ready_o` is high only in two cases: during a gap while no byte is held, or during a low-nibble cycle when the block still has bytes left to send. A complete single-block transfer takes exactly the programmed number of bytes from the source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe: the read command has ended, so begin a transfer |
| multi_i | input | 1 | Mode sampled with the start strobe: 1 = multiple blocks, 0 = single block |
| blk_len_i | input | LEN_W | Payload length in bytes, latched at start (must be at least 1) |
| access_dly_i | input | DLY_W | Access gap length NAC in cycles, latched at start (must be at least 2) |
| stop_i | input | 1 | One-cycle strobe marking the end bit of a stop command |
| byte_data_i | input | 2*LANES | Payload byte from the source |
| byte_valid_i | input | 1 | Source has a byte on `byte_data_i` |
| byte_ready_o | output | 1 | Transmitter takes the byte at this edge if valid |
| dat_o | output | LANES | Data line values |
| dat_oe_o | output | LANES | Output enable for each data line, active high |

## Verification
The assertions assume three things about the inputs. A transfer starts only with a nonzero block length and an access delay of at least two cycles. Once a block's first byte has been taken, the source keeps `byte_valid_i` high for every later request in that block, since the bus cannot pause mid-frame. The stop strobe never arrives while an earlier stop is still being served. The stimulus keeps within these limits: lengths are drawn from 1 to 6 and delays from 2 to 9. Valid is held back only before the first byte of the first block, to exercise the gap extension. Each stop is raised once per transfer, and the next transfer begins only after the turnaround has finished.

// File: rtl/brs_pkg.sv
package brs_pkg;

    localparam int CRC_W = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_GAP  = 3'd1,
        ST_DATA = 3'd2,
        ST_CRC  = 3'd3,
        ST_ENDB = 3'd4,
        ST_TURN = 3'd5
    } brs_state_e;

    // one serial step of the line CRC, message bit shifted in at the top
    function automatic logic [CRC_W-1:0] crc_next(input logic [CRC_W-1:0] c,
                                                 input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/brs_crc_lane.sv
module brs_crc_lane
    import brs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic upd_i,
    input  logic shift_i,
    input  logic bit_i,
    output logic msb_o
);

    logic [CRC_W-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr_i) begin
            crc_d = '0;
        end else if (upd_i) begin
            crc_d = crc_next(crc_q, bit_i);
        end else if (shift_i) begin
            crc_d = {crc_q[CRC_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign msb_o = crc_q[CRC_W-1];

endmodule

// File: rtl/brs_byte_hold.sv
module brs_byte_hold #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              want_i,
    input  logic              flush_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              valid_i,
    output logic              ready_o,
    output logic              take_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              have_o
);

    typedef struct packed {
        logic [BYTE_W-1:0] byte_v;
        logic              have;
    } hold_t;

    hold_t hd_d, hd_q;

    assign ready_o = want_i;
    assign take_o  = want_i & valid_i;

    always_comb begin
        hd_d = hd_q;
        if (take_o) begin
            hd_d.byte_v = data_i;
        end
        if (flush_i) begin
            hd_d.have = 1'b0;
        end else if (take_o) begin
            hd_d.have = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hd_q <= '0;
        end else begin
            hd_q <= hd_d;
        end
    end

    assign byte_o = hd_q.byte_v;
    assign have_o = hd_q.have;

endmodule

// File: rtl/blk_read_tx.sv
module blk_read_tx
    import brs_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LEN_W = 12,
    parameter int DLY_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 multi_i,
    input  logic [LEN_W-1:0]     blk_len_i,
    input  logic [DLY_W-1:0]     access_dly_i,
    input  logic                 stop_i,
    input  logic [2*LANES-1:0]   byte_data_i,
    input  logic                 byte_valid_i,
    output logic                 byte_ready_o,
    output logic [LANES-1:0]     dat_o,
    output logic [LANES-1:0]     dat_oe_o
);

    localparam int BYTE_W = 2 * LANES;
    localparam int WIDE_W = (LEN_W > DLY_W) ? LEN_W : DLY_W;
    localparam int CNT_W  = ((WIDE_W > 5) ? WIDE_W : 5) + 1;
    localparam logic [CNT_W-1:0] CRC_LAST = CNT_W'(CRC_W - 1);

    typedef struct packed {
        brs_state_e        st;
        logic              multi;
        logic [LEN_W-1:0]  len;
        logic [DLY_W-1:0]  nac;
        logic [CNT_W-1:0]  cnt;
        logic              lo;
        logic              stop;
        logic [LANES-1:0]  dat;
        logic              oe;
    } ctl_t;

    ctl_t cq, cd;

    logic              crc_clr, crc_upd, crc_sh;
    logic              want, flush, take, have;
    logic [BYTE_W-1:0] hold_byte;
    logic [LANES-1:0]  nib;
    logic [LANES-1:0]  lane_msb;
    logic              can_stop;
    brs_state_e        st_w;

    brs_byte_hold #(
        .BYTE_W (BYTE_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .want_i  (want),
        .flush_i (flush),
        .data_i  (byte_data_i),
        .valid_i (byte_valid_i),
        .ready_o (byte_ready_o),
        .take_o  (take),
        .byte_o  (hold_byte),
        .have_o  (have)
    );

    assign nib = cq.lo ? hold_byte[LANES-1:0] : hold_byte[BYTE_W-1:LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        brs_crc_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (crc_clr),
            .upd_i   (crc_upd),
            .shift_i (crc_sh),
            .bit_i   (nib[g]),
            .msb_o   (lane_msb[g])
        );
    end

    assign can_stop = !cq.stop && (cq.st == ST_GAP  || cq.st == ST_DATA ||
                                   cq.st == ST_CRC  || cq.st == ST_ENDB);
    assign st_w = cq.st;

    always_comb begin
        cd      = cq;
        crc_clr = 1'b0;
        crc_upd = 1'b0;
        crc_sh  = 1'b0;
        want    = 1'b0;
        flush   = 1'b0;

        if (cq.stop) begin
            // forced end bit, then turnaround
            cd.stop = 1'b0;
            cd.st   = ST_TURN;
            cd.cnt  = '0;
            cd.oe   = 1'b1;
            cd.dat  = '1;
            flush   = 1'b1;
        end else begin
            unique case (cq.st)
                ST_IDLE: begin
                    cd.oe  = 1'b0;
                    cd.dat = '1;
                    if (start_i) begin
                        cd.st    = ST_GAP;
                        cd.multi = multi_i;
                        cd.len   = blk_len_i;
                        cd.nac   = access_dly_i;
                        cd.cnt   = CNT_W'(1);
                        cd.oe    = (CNT_W'(access_dly_i) <= CNT_W'(1));
                        flush    = 1'b1;
                    end
                end
                ST_GAP: begin
                    want = !have;
                    if ((cq.cnt >= CNT_W'(cq.nac)) && (have || take)) begin
                        cd.st   = ST_DATA;
                        cd.oe   = 1'b1;
                        cd.dat  = '0;
                        cd.lo   = 1'b0;
                        cd.cnt  = '0;
                        crc_clr = 1'b1;
                    end else begin
                        if (cq.cnt != '1) begin
                            cd.cnt = cq.cnt + 1'b1;
                        end
                        cd.oe  = ((cq.cnt + 1'b1) >= CNT_W'(cq.nac));
                        cd.dat = '1;
                    end
                end
                ST_DATA: begin
                    cd.oe   = 1'b1;
                    cd.dat  = nib;
                    crc_upd = 1'b1;
                    if (!cq.lo) begin
                        cd.lo = 1'b1;
                    end else begin
                        cd.lo = 1'b0;
                        if ((cq.cnt + 1'b1) == CNT_W'(cq.len)) begin
                            cd.st  = ST_CRC;
                            cd.cnt = '0;
                            flush  = 1'b1;
                        end else begin
                            want   = 1'b1;
                            cd.cnt = cq.cnt + 1'b1;
                        end
                    end
                end
                ST_CRC: begin
                    cd.oe  = 1'b1;
                    cd.dat = lane_msb;
                    crc_sh = 1'b1;
                    if (cq.cnt == CRC_LAST) begin
                        cd.st  = ST_ENDB;
                        cd.cnt = '0;
                    end else begin
                        cd.cnt = cq.cnt + 1'b1;
                    end
                end
                ST_ENDB: begin
                    cd.oe  = 1'b1;
                    cd.dat = '1;
                    cd.cnt = '0;
                    cd.st  = cq.multi ? ST_GAP : ST_IDLE;
                end
                ST_TURN: begin
                    cd.oe  = 1'b0;
                    cd.dat = '1;
                    if (cq.cnt == CNT_W'(1)) begin
                        cd.st  = ST_IDLE;
                        cd.cnt = '0;
                    end else begin
                        cd.cnt = cq.cnt + 1'b1;
                    end
                end
                default: begin
                    cd.st = ST_IDLE;
                    cd.oe = 1'b0;
                end
            endcase
        end

        if (stop_i && can_stop) begin
            cd.stop = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cq       <= '0;
            cq.st    <= ST_IDLE;
            cq.dat   <= '1;
        end else begin
            cq <= cd;
        end
    end

    assign dat_o    = cq.dat;
    assign dat_oe_o = {LANES{cq.oe}};

endmodule

// File: rtl/blk_read_tx_chk.sv
module blk_read_tx_chk
    import brs_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LEN_W = 12,
    parameter int DLY_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             stop_i,
    input logic [LEN_W-1:0] blk_len_i,
    input logic [DLY_W-1:0] access_dly_i,
    input logic             byte_ready_o,
    input logic [LANES-1:0] dat_o,
    input logic [LANES-1:0] dat_oe_o,
    input brs_state_e       st,
    input logic             can_stop
);

    // input contract for a new transfer
    inputs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && st == ST_IDLE) |-> (access_dly_i >= DLY_W'(2) && blk_len_i != '0));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && $past(st) == ST_IDLE) |-> (dat_oe_o == '0 && !byte_ready_o));

    // R2
    start_after_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && $past(st) == ST_GAP) |->
            (dat_oe_o == '1 && dat_o == '0 && $past(dat_oe_o) == '1 && $past(dat_o) == '1));

    // R4
    end_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP && $past(st) == ST_ENDB) |-> (dat_oe_o == '1 && dat_o == '1));

    // R7
    stop_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && can_stop) |-> ##2 (dat_oe_o == '1 && dat_o == '1)
                                 ##1 (dat_oe_o == '0) ##1 (dat_oe_o == '0));

    // R10
    ready_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> (st == ST_GAP || st == ST_DATA));

endmodule

bind blk_read_tx blk_read_tx_chk #(
    .LANES (LANES),
    .LEN_W (LEN_W),
    .DLY_W (DLY_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .blk_len_i    (blk_len_i),
    .access_dly_i (access_dly_i),
    .byte_ready_o (byte_ready_o),
    .dat_o        (dat_o),
    .dat_oe_o     (dat_oe_o),
    .st           (st_w),
    .can_stop     (can_stop)
);

// File: tb/blk_read_tx_tb.sv
module blk_read_tx_tb;

    localparam int LANES = 4;
    localparam int LEN_W = 12;
    localparam int DLY_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             multi_i = 1'b0;
    logic [LEN_W-1:0] blk_len_i = '0;
    logic [DLY_W-1:0] access_dly_i = '0;
    logic             stop_i = 1'b0;
    logic [7:0]       byte_data_i;
    logic             byte_valid_i = 1'b1;
    logic             byte_ready_o;
    logic [3:0]       dat_o;
    logic [3:0]       dat_oe_o;

    int checks = 0;
    int bad = 0;
    int tr_seed = 0;
    int src_idx = 0;
    logic src_clr = 1'b0;

    always #10 clk = ~clk;

    blk_read_tx #(
        .LANES (LANES),
        .LEN_W (LEN_W),
        .DLY_W (DLY_W)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .multi_i      (multi_i),
        .blk_len_i    (blk_len_i),
        .access_dly_i (access_dly_i),
        .stop_i       (stop_i),
        .byte_data_i  (byte_data_i),
        .byte_valid_i (byte_valid_i),
        .byte_ready_o (byte_ready_o),
        .dat_o        (dat_o),
        .dat_oe_o     (dat_oe_o)
    );

    function automatic logic [7:0] byte_fn(input int s, input int i);
        return 8'((i * 53 + s * 7 + (i >> 2) * 11) ^ s);
    endfunction

    function automatic logic [15:0] crc_fn(input int line, input int s,
                                           input int blk, input int len);
        logic [15:0] c = '0;
        logic [7:0]  bv;
        logic        b;
        for (int j = 0; j < len; j++) begin
            bv = byte_fn(s, blk * len + j);
            for (int h = 0; h < 2; h++) begin
                b = (h == 0) ? bv[4 + line] : bv[line];
                c = (c[15] ^ b) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
            end
        end
        return c;
    endfunction

    always_comb byte_data_i = byte_fn(tr_seed, src_idx);

    always_ff @(posedge clk) begin
        if (src_clr) src_idx <= 0;
        else if (byte_ready_o && byte_valid_i) src_idx <= src_idx + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual {oe,dat}=%h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // expected {oe, dat} for output cycle n after the start edge
    task automatic exp_calc(input int n, input int len, input int nac, input int multi,
                            input int d, input int s, input int stop_n,
                            output logic [7:0] e, output string tag);
        int per, m, b, o, i, c;
        bit stop_on;
        logic [7:0]  bv;
        logic [15:0] cr;
        per = nac + 2 * len + 18;
        stop_on = (stop_n > 0) && (multi != 0 || stop_n < per + d);
        e = 8'h00;
        if (stop_on && n >= stop_n + 2) begin
            tag = "R7";
            e = (n == stop_n + 2) ? 8'hFF : 8'h00;
            return;
        end
        if (n <= nac + d) begin
            tag = (n > nac) ? "R9" : "R2";
            e = (n >= nac) ? 8'hFF : 8'h00;
            return;
        end
        m = n - d;
        b = (m - 1) / per;
        o = (m - 1) % per;
        if (multi == 0 && b >= 1) begin
            tag = "R5";
            return;
        end
        tag = (b > 0) ? "R6" : "R2";
        if (o < nac - 1) e = 8'h00;
        else if (o == nac - 1) e = 8'hFF;
        else if (o == nac) e = 8'hF0;
        else if (o <= nac + 2 * len) begin
            i = o - nac - 1;
            bv = byte_fn(s, b * len + i / 2);
            e = {4'hF, (i % 2 == 0) ? bv[7:4] : bv[3:0]};
            tag = "R3";
        end else if (o < per - 1) begin
            c = o - nac - 1 - 2 * len;
            e[7:4] = 4'hF;
            for (int l = 0; l < 4; l++) begin
                cr = crc_fn(l, s, b, len);
                e[l] = cr[15 - c];
            end
            tag = "R4";
        end else begin
            e = 8'hFF;
            tag = "R4";
        end
    endtask

    task automatic xfer(input int len, input int nac, input int multi, input int s,
                        input int stop_n, input int d, input int junk_n);
        int per, nmax;
        bit stop_on;
        logic [7:0] e, a;
        string tag;
        per = nac + 2 * len + 18;
        stop_on = (stop_n > 0) && (multi != 0 || stop_n < per + d);
        nmax = stop_on ? stop_n + 6 : per + d + 4;
        if (stop_n + 3 > nmax) nmax = stop_n + 3;
        @(negedge clk);
        tr_seed = s;
        blk_len_i = LEN_W'(len);
        access_dly_i = DLY_W'(nac);
        multi_i = (multi != 0);
        start_i = 1'b1;
        src_clr = 1'b1;
        byte_valid_i = (d == 0);
        for (int n = 1; n <= nmax; n++) begin
            @(negedge clk);
            start_i = 1'b0;
            src_clr = 1'b0;
            a = {dat_oe_o, dat_o};
            exp_calc(n, len, nac, multi, d, s, stop_n, e, tag);
            if (n == junk_n) tag = {tag, "/R8"};
            chk((e[7:4] == 4'h0) ? (a[7:4] == 4'h0) : (a == e), tag, a, e);
            stop_i = (n == stop_n);
            if (n == junk_n) begin
                start_i = 1'b1;
                blk_len_i = LEN_W'(len + 2);
                access_dly_i = DLY_W'(nac + 3);
                multi_i = (multi == 0);
            end
            if (d > 0 && n == nac + d) byte_valid_i = 1'b1;
        end
        stop_i = 1'b0;
        start_i = 1'b0;
        byte_valid_i = 1'b1;
        if (!stop_on && multi == 0) begin
            // R10: exact byte count for one block
            chk(src_idx == len, "R10", 8'(src_idx), 8'(len));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog: actual running expected done");
        $display("test done: total=%0d bad=%0d", checks + 1, bad + 1);
        $finish;
    end

    initial begin
        int len, nac, multi, stop_n, per;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: quiet during and after reset
        chk(dat_oe_o == 4'h0 && !byte_ready_o, "R1", {dat_oe_o, dat_o}, 8'h0F);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(dat_oe_o == 4'h0 && !byte_ready_o, "R1", {dat_oe_o, dat_o}, 8'h0F);

        // directed corners
        xfer(1, 2, 0, 11, 0, 0, 0);           // shortest block, shortest gap
        xfer(4, 5, 1, 12, 60, 0, 0);          // stop inside second block
        xfer(3, 3, 0, 13, 26, 0, 0);          // stop at single end bit edge
        xfer(2, 4, 0, 14, 0, 3, 0);           // gap extension (R9)
        xfer(3, 2, 1, 15, 70, 0, 9);          // start ignored mid-transfer
        xfer(2, 6, 1, 16, 2, 0, 0);           // stop during first gap

        // R8: stop while idle has no effect
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(dat_oe_o == 4'h0, "R8", {dat_oe_o, dat_o}, 8'h0F);
        end
        xfer(2, 3, 0, 17, 0, 0, 0);

        // constrained random transfers
        for (int t = 0; t < 40; t++) begin
            len = 1 + int'($urandom % 6);
            nac = 2 + int'($urandom % 8);
            multi = int'($urandom % 2);
            per = nac + 2 * len + 18;
            if (multi != 0) stop_n = 1 + int'($urandom % (3 * per));
            else stop_n = ($urandom % 3 == 0) ? 1 + int'($urandom % (per + 4)) : 0;
            xfer(len, nac, multi, 100 + t, stop_n, 0, 0);
        end

        @(negedge clk);
        chk(dat_oe_o == 4'h0 && !byte_ready_o, "R1", {dat_oe_o, dat_o}, 8'h0F);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule